// File: doc/BRIEF.md
# Ethernet Receive Packet Queue

This block takes received Ethernet frames, offered as a byte stream with a last-byte marker, and files each one as a record in a ring of packet slots. A record starts with a 2-byte little-endian length, carries the frame bytes, and ends with a CRC-32 that the block computes over the frame. Any bytes after the CRC in the last 32-bit word are zero.

The host drains records one 32-bit word at a time through a read strobe, and can watch a pending-record count and a sticky receive flag. The ring has a fixed number of slots, 31 by default. A frame is dropped when receive is disabled, when every slot is occupied, or when the frame is too long for a slot. A queue-reset pulse forgets every pending record.

Each new record goes into the slot that lies the pending count past the current read slot, so the ring is strictly first-in first-out.

Top module: `eth_rx_queue`

## Requirements
- R1: A frame whose first byte arrives while `rx_en` is low is dropped in full. The pending count does not change and `rx_flag` stays low.
- R2: At most NSLOT (31) records are pending. A frame whose first byte arrives while 31 are pending is dropped, and the count stays at 31.
- R3: Bits 15:0 of the first word of a record hold the record length, which is the frame size plus 6, least significant byte in bits 7:0.
- R4: Record byte i is returned in word i/4, bits 8*(i%4)+7 down to 8*(i%4). Frame byte k is record byte k+2.
- R5: The four record bytes after the frame hold the CRC-32 of the frame, least significant byte first. The CRC uses reflected polynomial 0xEDB88320, starts at all ones, and is inverted at the end.
- R6: Record bytes beyond the CRC in the final word of a record read as zero.
- R7: Storing a frame adds one to `pend_cnt` and sets `rx_flag`. The flag stays set until a `flag_clr` pulse without a concurrent store.
- R8: A `rd_req` pulse updates `rd_data` in the following cycle. The read of a record's last word, which is word ceil((size+6)/4)-1, lowers `pend_cnt` by one, and the next read starts the next record in ring order. The slot index wraps from 30 back to 0.
- R9: A `rd_req` while no record is pending returns zero and changes no state.
- R10: A `fifo_clr` pulse sets `pend_cnt` to 0, sets the read position to word 0, and aborts any frame being received. The next stored frame is read back from its first word.
- R11: A slot holds SLOT_WORDS*4 bytes, so frames of up to 250 bytes are stored. Longer frames are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_en | input | 1 | Receive enable, sampled at each frame's first byte |
| fifo_clr | input | 1 | Queue reset pulse |
| in_valid | input | 1 | A frame byte is present on `in_byte` |
| in_byte | input | 8 | Frame byte |
| in_last | input | 1 | Marks the final byte of a frame; at least two idle cycles must follow |
| rd_req | input | 1 | Read-word strobe |
| flag_clr | input | 1 | Clears `rx_flag` |
| rd_data | output | 32 | Word returned by the last read |
| pend_cnt | output | 5 | Number of pending records |
| rx_flag | output | 1 | Sticky frame-stored flag |

## Verification
Every cycle, assertions check the following: the pending count never passes the ring size, a queue reset empties the ring, each store raises the flag, and each store or final-word read moves the count by exactly one. They also check that the input stream leaves the flush cycles idle. Only the bench's scenarios can show that record contents are right: the length field, the byte lanes, the CRC bytes and the zero padding. The same holds for ring order across the slot wrap, for drops caused by a full ring, an over-long frame or disabled receive, and for reading from the first word after a queue reset.

// File: rtl/eth_rxq_pkg.sv
// Package: shared state encoding and the byte-wise CRC-32 step.
// Assumes reflected CRC-32 arithmetic (LSB first), as used on Ethernet.
package eth_rxq_pkg;

    localparam logic [31:0] CRC_POLY_REFL = 32'hEDB88320;

    // Receive-side framing states
    typedef enum logic [2:0] {
        W_IDLE  = 3'd0,   // waiting for the first byte of a frame
        W_RECV  = 3'd1,   // accepting bytes of a frame being stored
        W_SKIP  = 3'd2,   // discarding bytes of a dropped frame
        W_FLA   = 3'd3,   // writing the word that holds the first CRC bytes
        W_FLB   = 3'd4    // writing the spill-over CRC word
    } rxw_state_e;

    // One byte of reflected CRC-32
    function automatic logic [31:0] crc32_step(input logic [31:0] c_in, input logic [7:0] b);
        logic [31:0] c;
        c = c_in ^ {24'h0, b};
        for (int i = 0; i < 8; i++) begin
            c = c[0] ? ((c >> 1) ^ CRC_POLY_REFL) : (c >> 1);
        end
        return c;
    endfunction

endpackage

// File: rtl/eth_rxq_crc.sv
// Module: running CRC-32 register.
// Loads all ones and folds in the byte when init is high; otherwise folds
// the byte into the held value. The output is the raw register; the final
// inversion is the caller's job.
module eth_rxq_crc
    import eth_rxq_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        en,
    input  logic        init,
    input  logic [7:0]  data,
    output logic [31:0] crc_q
);

    // Advance the CRC by one byte when enabled
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            crc_q <= '1;
        end else if (en) begin
            crc_q <= crc32_step(init ? 32'hFFFF_FFFF : crc_q, data);
        end
    end

endmodule

// File: rtl/eth_rxq_writer.sv
// Module: frame intake. Packs bytes into 32-bit record words starting at
// byte offset 2, drops frames that are disabled, too long or arrive with the
// ring full, and after the last byte writes one or two CRC words, then
// commits the record. Lanes 0-1 of word 0 are left zero; the store fills
// them with the length at read time.
// Assumes at least two idle input cycles after each in_last.
module eth_rxq_writer
    import eth_rxq_pkg::*;
#(
    parameter int NSLOT      = 31,
    parameter int SLOT_WORDS = 64
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              rx_en,
    input  logic                              fifo_clr,
    input  logic                              full,
    input  logic [$clog2(NSLOT)-1:0]          wslot,
    input  logic                              in_valid,
    input  logic [7:0]                        in_byte,
    input  logic                              in_last,
    output logic                              mem_we,
    output logic [$clog2(NSLOT)-1:0]          mem_slot,
    output logic [$clog2(SLOT_WORDS)-1:0]     mem_off,
    output logic [31:0]                       mem_data,
    output logic                              commit,
    output logic [$clog2(NSLOT)-1:0]          commit_slot,
    output logic [$clog2(SLOT_WORDS*4+1)-1:0] commit_len
);

    localparam int SLOT_W    = $clog2(NSLOT);
    localparam int OFF_W     = $clog2(SLOT_WORDS);
    localparam int LEN_W     = $clog2(SLOT_WORDS*4+1);
    localparam int POS_W     = OFF_W + 2;
    localparam int MAX_FRAME = SLOT_WORDS*4 - 6;

    rxw_state_e         st;
    rxw_state_e         st_n;
    logic [LEN_W-1:0]   cnt;
    logic [LEN_W-1:0]   cnt_eff;
    logic [31:0]        asm_q;
    logic [31:0]        asm_base;
    logic [SLOT_W-1:0]  slot_q;
    logic [POS_W-1:0]   pos;
    logic [1:0]         lane;
    logic [OFF_W-1:0]   widx;
    logic               start_ok;
    logic               take;
    logic [31:0]        crc_q;
    logic [31:0]        crc_fin;
    logic [31:0]        word_a;
    logic [31:0]        word_b;

    eth_rxq_crc u_crc (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (take),
        .init  (st == W_IDLE),
        .data  (in_byte),
        .crc_q (crc_q)
    );

    // Byte position within the record and acceptance of the current byte
    always_comb begin
        cnt_eff  = (st == W_IDLE) ? '0 : cnt;
        pos      = POS_W'(cnt_eff) + POS_W'(2);
        lane     = pos[1:0];
        widx     = pos[POS_W-1:2];
        start_ok = rx_en && !full;
        take     = in_valid && !fifo_clr &&
                   (((st == W_IDLE) && start_ok) ||
                    ((st == W_RECV) && (cnt < LEN_W'(MAX_FRAME))));
        asm_base = (st == W_IDLE) ? 32'h0 : asm_q;
        crc_fin  = ~crc_q;
    end

    // CRC words: A merges held lanes with leading CRC bytes, B holds the rest
    always_comb begin
        word_a = '0;
        word_b = '0;
        for (int j = 0; j < 4; j++) begin
            if (j < int'(lane)) begin
                word_a[8*j +: 8] = asm_q[8*j +: 8];
                word_b[8*j +: 8] = crc_fin[8*(4 - int'(lane) + j) +: 8];
            end else begin
                word_a[8*j +: 8] = crc_fin[8*(j - int'(lane)) +: 8];
            end
        end
    end

    // Memory write port and commit strobe
    always_comb begin
        mem_we   = 1'b0;
        mem_slot = slot_q;
        mem_off  = widx;
        mem_data = word_a;
        if (take && (lane == 2'd3)) begin
            mem_we   = 1'b1;
            mem_data = {in_byte, asm_base[23:0]};
        end else if ((st == W_FLA) && !fifo_clr) begin
            mem_we   = 1'b1;
        end else if ((st == W_FLB) && !fifo_clr) begin
            mem_we   = 1'b1;
            mem_off  = widx + OFF_W'(1);
            mem_data = word_b;
        end
        commit      = !fifo_clr && (((st == W_FLA) && (lane == 2'd0)) || (st == W_FLB));
        commit_slot = slot_q;
        commit_len  = cnt + LEN_W'(6);
    end

    // Next framing state
    always_comb begin
        st_n = st;
        case (st)
            W_IDLE: if (in_valid) begin
                if (take) st_n = in_last ? W_FLA : W_RECV;
                else      st_n = in_last ? W_IDLE : W_SKIP;
            end
            W_RECV: begin
                if (in_valid && in_last) st_n = take ? W_FLA : W_IDLE;
                else if (fifo_clr)       st_n = W_SKIP;
                else if (in_valid && !take) st_n = W_SKIP;
            end
            W_SKIP: if (in_valid && in_last) st_n = W_IDLE;
            W_FLA:  st_n = (fifo_clr || (lane == 2'd0)) ? W_IDLE : W_FLB;
            W_FLB:  st_n = W_IDLE;
            default: st_n = W_IDLE;
        endcase
    end

    // Framing registers: state, byte count, word assembler, target slot
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= W_IDLE;
            cnt    <= '0;
            asm_q  <= '0;
            slot_q <= '0;
        end else begin
            st <= st_n;
            if (take) begin
                cnt <= cnt_eff + LEN_W'(1);
                if (lane == 2'd3) begin
                    asm_q <= '0;
                end else begin
                    asm_q                <= asm_base;
                    asm_q[8*lane +: 8]   <= in_byte;
                end
            end
            if ((st == W_IDLE) && take) slot_q <= wslot;
        end
    end

    // Input stream must stay idle while CRC words are written (record layout)
    assert_gap_after_last_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((st == W_FLA) || (st == W_FLB)) |-> !in_valid);

endmodule

// File: rtl/eth_rxq_store.sv
// Module: record storage. One word array addressed by {slot, word} and a
// per-slot length table. The read port is synchronous; word 0 of a record
// gets the stored length in bits 15:0. A read with nothing pending yields 0.
// Assumes SLOT_WORDS is a power of two.
module eth_rxq_store #(
    parameter int NSLOT      = 31,
    parameter int SLOT_WORDS = 64
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              we,
    input  logic [$clog2(NSLOT)-1:0]          w_slot,
    input  logic [$clog2(SLOT_WORDS)-1:0]     w_off,
    input  logic [31:0]                       w_data,
    input  logic                              len_we,
    input  logic [$clog2(NSLOT)-1:0]          len_slot,
    input  logic [$clog2(SLOT_WORDS*4+1)-1:0] len_val,
    input  logic                              rd_req,
    input  logic                              rd_hit,
    input  logic [$clog2(NSLOT)-1:0]          r_slot,
    input  logic [$clog2(SLOT_WORDS)-1:0]     r_off,
    output logic [$clog2(SLOT_WORDS*4+1)-1:0] cur_len,
    output logic [31:0]                       rd_data
);

    localparam int SLOT_W = $clog2(NSLOT);
    localparam int OFF_W  = $clog2(SLOT_WORDS);
    localparam int LEN_W  = $clog2(SLOT_WORDS*4+1);
    localparam int DEPTH  = 2**(SLOT_W + OFF_W);

    logic [31:0]      mem  [DEPTH];
    logic [LEN_W-1:0] lens [NSLOT];
    logic [31:0]      rd_word;

    // Record word write port
    always_ff @(posedge clk) begin
        if (we) mem[{w_slot, w_off}] <= w_data;
    end

    // Length table write on commit
    always_ff @(posedge clk) begin
        if (len_we) lens[len_slot] <= len_val;
    end

    // Length of the record currently being read
    always_comb begin
        cur_len = lens[r_slot];
        rd_word = mem[{r_slot, r_off}];
    end

    // Synchronous read with the length merged into word 0
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (rd_req) begin
            if (!rd_hit)           rd_data <= '0;
            else if (r_off == '0)  rd_data <= {rd_word[31:16], {(16-LEN_W){1'b0}}, cur_len};
            else                   rd_data <= rd_word;
        end
    end

endmodule

// File: rtl/eth_rxq_ctrl.sv
// Module: ring bookkeeping. Holds the read slot, the word offset within the
// record being read and the pending count, and derives the write slot as
// read slot plus pending count, modulo NSLOT.
// Assumes commits arrive only for slots obtained while not full.
module eth_rxq_ctrl #(
    parameter int NSLOT      = 31,
    parameter int SLOT_WORDS = 64
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              fifo_clr,
    input  logic                              rd_req,
    input  logic                              commit,
    input  logic [$clog2(SLOT_WORDS*4+1)-1:0] cur_len,
    output logic                              rd_hit,
    output logic [$clog2(NSLOT)-1:0]          rslot,
    output logic [$clog2(SLOT_WORDS)-1:0]     roff,
    output logic [$clog2(NSLOT)-1:0]          wslot,
    output logic [$clog2(NSLOT+1)-1:0]        pend,
    output logic                              full
);

    localparam int SLOT_W = $clog2(NSLOT);
    localparam int OFF_W  = $clog2(SLOT_WORDS);
    localparam int LEN_W  = $clog2(SLOT_WORDS*4+1);
    localparam int PEND_W = $clog2(NSLOT+1);
    localparam int SUM_W  = SLOT_W + 1;

    logic [LEN_W-1:0] nwords;
    logic             last_word;
    logic             pop;
    logic [SUM_W-1:0] wsum;

    // Read hit, end-of-record detection and write-slot derivation
    always_comb begin
        rd_hit    = rd_req && !fifo_clr && (pend != '0);
        nwords    = (cur_len + LEN_W'(3)) >> 2;
        last_word = (LEN_W'(roff) == (nwords - LEN_W'(1)));
        pop       = rd_hit && last_word;
        wsum      = SUM_W'(rslot) + SUM_W'(pend);
        wslot     = (wsum >= SUM_W'(NSLOT)) ? SLOT_W'(wsum - SUM_W'(NSLOT)) : SLOT_W'(wsum);
        full      = (pend == PEND_W'(NSLOT));
    end

    // Read pointer and pending count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rslot <= '0;
            roff  <= '0;
            pend  <= '0;
        end else if (fifo_clr) begin
            roff  <= '0;
            pend  <= '0;
        end else begin
            if (pop) begin
                roff  <= '0;
                rslot <= (rslot == SLOT_W'(NSLOT-1)) ? '0 : rslot + SLOT_W'(1);
            end else if (rd_hit) begin
                roff  <= roff + OFF_W'(1);
            end
            pend <= pend + PEND_W'(commit) - PEND_W'(pop);
        end
    end

    assert_no_store_when_full_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !pop) |-> !commit);

    assert_clr_empties_R10: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_clr |=> (pend == '0) && (roff == '0));

    assert_store_counts_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && !pop && !fifo_clr) |=> pend == $past(pend) + PEND_W'(1));

    assert_pop_counts_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !commit && !fifo_clr) |=> pend == $past(pend) - PEND_W'(1));

    assert_empty_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && (pend == '0) && !commit && !fifo_clr) |=> (pend == '0) && $stable(rslot) && $stable(roff));

endmodule

// File: rtl/eth_rx_queue.sv
// Module: top of the receive packet queue. Wires frame intake, record
// storage and ring bookkeeping, and keeps the sticky receive flag.
// Assumes a byte stream with at least two idle cycles after each last byte.
module eth_rx_queue #(
    parameter int NSLOT      = 31,
    parameter int SLOT_WORDS = 64
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         rx_en,
    input  logic                         fifo_clr,
    input  logic                         in_valid,
    input  logic [7:0]                   in_byte,
    input  logic                         in_last,
    input  logic                         rd_req,
    input  logic                         flag_clr,
    output logic [31:0]                  rd_data,
    output logic [$clog2(NSLOT+1)-1:0]   pend_cnt,
    output logic                         rx_flag
);

    localparam int SLOT_W = $clog2(NSLOT);
    localparam int OFF_W  = $clog2(SLOT_WORDS);
    localparam int LEN_W  = $clog2(SLOT_WORDS*4+1);

    logic              mem_we;
    logic [SLOT_W-1:0] mem_slot;
    logic [OFF_W-1:0]  mem_off;
    logic [31:0]       mem_data;
    logic              commit;
    logic [SLOT_W-1:0] commit_slot;
    logic [LEN_W-1:0]  commit_len;
    logic [LEN_W-1:0]  cur_len;
    logic              rd_hit;
    logic [SLOT_W-1:0] rslot;
    logic [OFF_W-1:0]  roff;
    logic [SLOT_W-1:0] wslot;
    logic              full;

    eth_rxq_writer #(.NSLOT(NSLOT), .SLOT_WORDS(SLOT_WORDS)) u_writer (
        .clk         (clk),
        .rst_n       (rst_n),
        .rx_en       (rx_en),
        .fifo_clr    (fifo_clr),
        .full        (full),
        .wslot       (wslot),
        .in_valid    (in_valid),
        .in_byte     (in_byte),
        .in_last     (in_last),
        .mem_we      (mem_we),
        .mem_slot    (mem_slot),
        .mem_off     (mem_off),
        .mem_data    (mem_data),
        .commit      (commit),
        .commit_slot (commit_slot),
        .commit_len  (commit_len)
    );

    eth_rxq_store #(.NSLOT(NSLOT), .SLOT_WORDS(SLOT_WORDS)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (mem_we),
        .w_slot   (mem_slot),
        .w_off    (mem_off),
        .w_data   (mem_data),
        .len_we   (commit),
        .len_slot (commit_slot),
        .len_val  (commit_len),
        .rd_req   (rd_req),
        .rd_hit   (rd_hit),
        .r_slot   (rslot),
        .r_off    (roff),
        .cur_len  (cur_len),
        .rd_data  (rd_data)
    );

    eth_rxq_ctrl #(.NSLOT(NSLOT), .SLOT_WORDS(SLOT_WORDS)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .fifo_clr (fifo_clr),
        .rd_req   (rd_req),
        .commit   (commit),
        .cur_len  (cur_len),
        .rd_hit   (rd_hit),
        .rslot    (rslot),
        .roff     (roff),
        .wslot    (wslot),
        .pend     (pend_cnt),
        .full     (full)
    );

    // Sticky receive flag: a store wins over a clear in the same cycle
    always_ff @(posedge clk) begin
        if (!rst_n)        rx_flag <= 1'b0;
        else if (commit)   rx_flag <= 1'b1;
        else if (flag_clr) rx_flag <= 1'b0;
    end

    assert_flag_on_store_R7: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> rx_flag);

endmodule

// File: tb/eth_rx_queue_tb.sv
module eth_rx_queue_tb;

    localparam int NSLOT      = 31;
    localparam int SLOT_WORDS = 64;
    localparam int MAXF       = SLOT_WORDS*4 - 6;

    logic        clk = 1'b0;
    logic        rst_n, rx_en, fifo_clr, in_valid, in_last, rd_req, flag_clr;
    logic [7:0]  in_byte;
    logic [31:0] rd_data;
    logic [4:0]  pend_cnt;
    logic        rx_flag;

    always #5 clk = ~clk;

    eth_rx_queue #(.NSLOT(NSLOT), .SLOT_WORDS(SLOT_WORDS)) u_dut (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .fifo_clr(fifo_clr),
        .in_valid(in_valid), .in_byte(in_byte), .in_last(in_last),
        .rd_req(rd_req), .flag_clr(flag_clr), .rd_data(rd_data),
        .pend_cnt(pend_cnt), .rx_flag(rx_flag)
    );

    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    // Bench model of the ring: frame bytes per slot
    logic [7:0] mq [NSLOT][256];
    int         mlen [NSLOT];
    int         mhead = 0, mcnt = 0;
    logic [7:0] fbuf [260];

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] crc_ref(input int s);
        logic [31:0] c = 32'hFFFF_FFFF;
        for (int i = 0; i < mlen[s]; i++) begin
            c = c ^ {24'h0, mq[s][i]};
            for (int k = 0; k < 8; k++) c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
        end
        return ~c;
    endfunction

    function automatic logic [7:0] rec_byte(input int s, input int i, input logic [31:0] c);
        int n = mlen[s];
        logic [15:0] l = 16'(n + 6);
        if (i == 0) return l[7:0];
        if (i == 1) return l[15:8];
        if (i < n + 2) return mq[s][i-2];
        if (i < n + 6) return c[8*(i-n-2) +: 8];
        return 8'h00;
    endfunction

    task automatic send(input int len);
        bit ok = rx_en && (mcnt < NSLOT) && (len <= MAXF);
        int s = (mhead + mcnt) % NSLOT;
        for (int i = 0; i < len; i++) fbuf[i] = 8'($urandom);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            in_valid = 1'b1; in_byte = fbuf[i]; in_last = (i == len-1);
        end
        @(negedge clk);
        in_valid = 1'b0; in_last = 1'b0;
        repeat (3) @(negedge clk);
        if (ok) begin
            for (int i = 0; i < len; i++) mq[s][i] = fbuf[i];
            mlen[s] = len;
            mcnt++;
        end
    endtask

    task automatic read_word(output logic [31:0] w);
        @(negedge clk); rd_req = 1'b1;
        @(negedge clk); rd_req = 1'b0;
        w = rd_data;
    endtask

    task automatic read_rec();
        int s = mhead;
        int n = mlen[s];
        int words = (n + 6 + 3) / 4;
        logic [31:0] c = crc_ref(s);
        logic [31:0] got, exp;
        string tag;
        for (int w = 0; w < words; w++) begin
            read_word(got);
            for (int j = 0; j < 4; j++) exp[8*j +: 8] = rec_byte(s, 4*w + j, c);
            if (w == 0) tag = "R3 length word";
            else if ((w == words-1) && (((n + 6) % 4) != 0)) tag = "R6 padded last word";
            else if (4*w + 3 >= n + 2) tag = "R5 crc word";
            else tag = "R4 data word";
            chk(tag, got, exp);
        end
        mhead = (mhead + 1) % NSLOT;
        mcnt--;
        chk("R8 pending after record read", 32'(pend_cnt), 32'(mcnt));
    endtask

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL R8 watchdog expired actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] w;
        int unsigned seed;
        seed = $urandom(32'd20240607);
        rst_n = 0; rx_en = 0; fifo_clr = 0; in_valid = 0; in_last = 0;
        in_byte = 0; rd_req = 0; flag_clr = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R7 reset pending", 32'(pend_cnt), 0);
        chk("R7 reset flag", 32'(rx_flag), 0);
        chk("R9 reset data", rd_data, 0);

        // R1: receive disabled
        send(12);
        chk("R1 pending while disabled", 32'(pend_cnt), 0);
        chk("R1 flag while disabled", 32'(rx_flag), 0);
        rx_en = 1;

        // Directed lane coverage then random rounds
        for (int len = 1; len <= 4; len++) send(len);
        chk("R7 pending after four frames", 32'(pend_cnt), 4);
        chk("R7 flag set", 32'(rx_flag), 1);
        @(negedge clk); flag_clr = 1; @(negedge clk); flag_clr = 0;
        chk("R7 flag cleared", 32'(rx_flag), 0);
        while (mcnt > 0) read_rec();
        read_word(w);
        chk("R9 empty read data", w, 0);
        chk("R9 empty read pending", 32'(pend_cnt), 0);

        for (int r = 0; r < 8; r++) begin
            int nf = $urandom_range(1, 3);
            for (int f = 0; f < nf; f++) send($urandom_range(1, 70));
            chk("R7 pending after random frames", 32'(pend_cnt), 32'(mcnt));
            while (mcnt > 0) read_rec();
        end

        // R11: slot size boundary
        send(MAXF + 1);
        chk("R11 oversize frame dropped", 32'(pend_cnt), 0);
        send(MAXF);
        chk("R11 largest frame stored", 32'(pend_cnt), 1);
        read_rec();

        // R2: fill the ring across the slot wrap, then one more
        for (int f = 0; f < NSLOT; f++) send($urandom_range(1, 9));
        chk("R2 ring full", 32'(pend_cnt), NSLOT);
        send(5);
        chk("R2 frame dropped when full", 32'(pend_cnt), NSLOT);
        while (mcnt > 0) read_rec();

        // R10: queue reset mid-record
        send(10); send(15);
        read_word(w);
        chk("R10 pending before reset", 32'(pend_cnt), 2);
        @(negedge clk); fifo_clr = 1; @(negedge clk); fifo_clr = 0;
        mcnt = 0;
        chk("R10 pending after reset", 32'(pend_cnt), 0);
        read_word(w);
        chk("R10 empty after reset", w, 0);
        send(21);
        read_rec();

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule